// File: doc/BRIEF.md
# DMA Peripheral Request Router

This block sits between the hardware request lines of the peripherals and the request inputs of the DMA channels. It keeps one small mapping slot per peripheral request ID. Software writes into a slot the number of the channel that should serve that peripheral, offset by one, so that a slot holding zero marks the peripheral as not routed. Request ID 0 stands for software-triggered transfers. It has no line and no slot.

Every clock the router samples the level-sensitive peripheral request lines. It raises the request output of each channel that at least one active, mapped peripheral points to. Several peripherals may share a channel, and their requests then merge onto that channel's output. Slots are written and read back over a simple single-cycle register bus. The slot array sits at a fixed base offset inside the controller's address space. The channel datapath and arbitration between channels belong to other blocks.

Top module: `req_router`

## Requirements
- R1: After reset every slot reads back as zero and every bit of `chan_req` is zero. While reset is held, `chan_req` stays zero whatever the request lines do.
- R2: The slot of request ID u (1 to NUM_REQ) sits at byte address 0x2000 + 4*(u-1). A cycle with `bus_sel`=1 and `bus_wr`=1 stores `bus_wdata[SLOT_W-1:0]` into it, where SLOT_W = clog2(NUM_CH+1). A cycle with `bus_sel`=1 and `bus_wr`=0 returns the slot, zero-extended, on `bus_rdata` in the following cycle.
- R3: Some addresses decode to no slot: those below 0x2000 (the place request ID 0 would take), those at or beyond 0x2000 + 4*NUM_REQ, and those that are not word aligned. Writes to them change no slot, and reads of them return zero. `bus_rdata` is zero in every cycle that does not follow a read.
- R4: `periph_req` bit u-1 carries request ID u. A slot value v in 1..NUM_CH forwards that bit to `chan_req[v-1]`, with one clock of latency: the output after an edge reflects the lines sampled at that edge.
- R5: A peripheral whose slot holds zero has no effect on any `chan_req` bit, and `chan_req` is all zero after an edge at which no request line was high.
- R6: A slot value greater than NUM_CH (for example 9 or 15 when NUM_CH is 8) is treated as unmapped, and requests from that peripheral are ignored.
- R7: When several peripherals map to the same channel, their requests are ORed onto that channel's output. No more `chan_req` bits are ever high than request lines were high one cycle earlier.
- R8: A slot write takes effect at the edge that performs it. A request sampled at that same edge still uses the old mapping, and a request sampled at the next edge uses the new one.
- R9: Write data bits at and above SLOT_W are discarded and read back as zero. For example, writing 0x35 with NUM_CH = 8 stores 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the controller space |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| periph_req | input | NUM_REQ | Level request lines, bit u-1 is request ID u |
| chan_req | output | NUM_CH | Forwarded request per DMA channel |

## Verification
The hardest situation to reach from the ports is a remap that lands in the same cycle as an active request. That case separates a design that routes through the freshly written slot from one that routes through the slot as it stood at the sampling edge. The stimulus raises a request line in the same cycle as the write that maps it and holds the line over the next cycle. The scoreboard expects nothing on the first edge and the new channel on the second. Sharing a channel, out-of-range slot values and truncated write data are reached by writing those values and then driving single and combined request patterns.

// File: rtl/rtr_pkg.sv
`timescale 1ns/1ps
package rtr_pkg;

    // Byte offset of the first mapping slot inside the controller space.
    localparam logic [31:0] SLOT_BASE = 32'h0000_2000;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_op_e;

    typedef struct packed {
        logic        hit;
        logic [15:0] idx;
    } slot_dec_t;

    function automatic bus_op_e bus_op(input logic sel, input logic wr);
        if (!sel)
            return BUS_IDLE;
        return wr ? BUS_WRITE : BUS_READ;
    endfunction

    // Slot index is (addr - base) / 4; only aligned addresses inside the
    // slot array decode to a slot.
    function automatic slot_dec_t decode_slot(input logic [31:0] addr,
                                              input int unsigned nreq);
        slot_dec_t   d;
        logic [31:0] off;
        off   = addr - SLOT_BASE;
        d.idx = off[17:2];
        d.hit = (addr >= SLOT_BASE) && (off[1:0] == 2'b00) &&
                (32'(off[31:2]) < nreq);
        return d;
    endfunction

endpackage

// File: rtl/rtr_slot_regs.sv
`timescale 1ns/1ps
module rtr_slot_regs #(
    parameter int NUM_REQ = 16,
    parameter int NUM_CH  = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int SLOT_W  = $clog2(NUM_CH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NUM_REQ*SLOT_W-1:0] slots_flat
);
    import rtr_pkg::*;

    bus_op_e           op;
    slot_dec_t         dec;
    logic [SLOT_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_wdata;

    assign op  = bus_op(bus_sel, bus_wr);
    assign dec = decode_slot(32'(bus_addr), NUM_REQ);
    assign unused_wdata = ^bus_wdata[DATA_W-1:SLOT_W];

    for (genvar u = 0; u < NUM_REQ; u++) begin : g_slot
        logic [SLOT_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= '0;
            else if (op == BUS_WRITE && dec.hit && dec.idx == 16'(u))
                val_q <= bus_wdata[SLOT_W-1:0];
        end
        assign slots_flat[u*SLOT_W +: SLOT_W] = val_q;
    end

    always_comb begin
        rd_val = '0;
        for (int u = 0; u < NUM_REQ; u++)
            if (dec.idx == 16'(u))
                rd_val = slots_flat[u*SLOT_W +: SLOT_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (op == BUS_READ && dec.hit)
            rdata_q <= {{(DATA_W-SLOT_W){1'b0}}, rd_val};
        else
            rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/rtr_xbar.sv
`timescale 1ns/1ps
module rtr_xbar #(
    parameter int NUM_REQ = 16,
    parameter int NUM_CH  = 8,
    parameter int SLOT_W  = $clog2(NUM_CH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_REQ-1:0]        periph_req,
    input  logic [NUM_REQ*SLOT_W-1:0] slots_flat,
    output logic [NUM_CH-1:0]         chan_req
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [SLOT_W-1:0] CODE = SLOT_W'(c + 1);
        logic [NUM_REQ-1:0] match;
        logic               req_q;

        for (genvar u = 0; u < NUM_REQ; u++) begin : g_src
            assign match[u] = periph_req[u] &&
                              (slots_flat[u*SLOT_W +: SLOT_W] == CODE);
        end

        always_ff @(posedge clk) begin
            if (rst)
                req_q <= 1'b0;
            else
                req_q <= |match;
        end
        assign chan_req[c] = req_q;
    end

endmodule

// File: rtl/req_router.sv
`timescale 1ns/1ps
module req_router #(
    parameter int NUM_REQ = 16,
    parameter int NUM_CH  = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_REQ-1:0] periph_req,
    output logic [NUM_CH-1:0]  chan_req
);
    localparam int SLOT_W = $clog2(NUM_CH + 1);

    logic [NUM_REQ*SLOT_W-1:0] slots_flat;

    rtr_slot_regs #(
        .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .SLOT_W(SLOT_W)
    ) u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slots_flat(slots_flat)
    );

    rtr_xbar #(
        .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .SLOT_W(SLOT_W)
    ) u_xbar (
        .clk(clk), .rst(rst), .periph_req(periph_req),
        .slots_flat(slots_flat), .chan_req(chan_req)
    );

endmodule

// File: rtl/req_router_chk.sv
`timescale 1ns/1ps
module req_router_chk #(
    parameter int NUM_REQ = 16,
    parameter int NUM_CH  = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_REQ-1:0] periph_req,
    input logic [NUM_CH-1:0]  chan_req
);
    localparam int SLOT_W = $clog2(NUM_CH + 1);
    logic unused_chk;
    assign unused_chk = ^bus_wdata;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (chan_req == '0 && bus_rdata == '0));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (periph_req == '0) |=> (chan_req == '0));

    // R7
    fanout_bound_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(chan_req) <= $countones($past(periph_req)));

    // R3
    low_addr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && (32'(bus_addr) < 32'h2000)) |=> (bus_rdata == '0));

    // R3
    no_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> (bus_rdata == '0));

    // R9
    rdata_width_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:SLOT_W] == '0);

endmodule

bind req_router req_router_chk #(
    .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/req_router_test.sv
`timescale 1ns/1ps
module req_router_test;
    localparam int NREQ = 16;
    localparam int NCH  = 8;
    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int SW   = $clog2(NCH + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [NREQ-1:0] periph_req = '0;
    logic [NCH-1:0]  chan_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int mslot [NREQ];

    typedef struct {
        logic [NCH-1:0] exp;
        string          tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    sb_item_t mon_item;

    always #2 clk = ~clk;

    req_router #(.NUM_REQ(NREQ), .NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_req(periph_req), .chan_req(chan_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [AW-1:0] a);
        int off;
        off = int'(a) - 32'h2000;
        if (int'(a) < 32'h2000 || a[1:0] != 2'b00 || off >= 4 * NREQ)
            return -1;
        return off / 4;
    endfunction

    function automatic logic [NCH-1:0] model(input logic [NREQ-1:0] v);
        logic [NCH-1:0] r = '0;
        for (int u = 0; u < NREQ; u++)
            if (v[u] && mslot[u] >= 1 && mslot[u] <= NCH)
                r[mslot[u]-1] = 1'b1;
        return r;
    endfunction

    function automatic logic [AW-1:0] sa(input int id);
        return AW'(32'h2000 + 4 * (id - 1));
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int s;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        s = slot_of(a);
        if (s >= 0) mslot[s] = int'(d[SW-1:0]);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        int s;
        logic [31:0] exp;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        s = slot_of(a);
        exp = (s >= 0) ? 32'(mslot[s]) : 32'h0;
        @(posedge clk); #1;
        check(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic drive(input logic [NREQ-1:0] v, input string tag);
        sb_item_t it;
        @(negedge clk);
        periph_req = v;
        it.exp = model(v);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compares the output one edge after each driven pattern
    initial forever begin
        @(posedge clk); #1;
        if (sb_q.size() > 0) begin
            mon_item = sb_q.pop_front();
            check(mon_item.tag, 32'(chan_req), 32'(mon_item.exp));
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        sb_item_t it;
        for (int u = 0; u < NREQ; u++) mslot[u] = 0;
        periph_req = '1;
        repeat (3) @(negedge clk);
        check("R1 chan_req held low in reset", 32'(chan_req), 32'h0);
        periph_req = '0;
        rst = 1'b0;
        rd(sa(1), "R1 slot 1 after reset");
        rd(sa(NREQ), "R1 last slot after reset");

        // R2 map and read back
        wr(sa(1), 32'd3);
        wr(sa(5), 32'd1);
        wr(sa(NREQ), 32'(NCH));
        rd(sa(1), "R2 slot 1 readback");
        rd(sa(5), "R2 slot 5 readback");
        rd(sa(NREQ), "R2 last slot readback");

        // R3 addresses with no slot
        wr(16'h1FFC, 32'd2);
        rd(16'h1FFC, "R3 below base reads zero");
        wr(sa(NREQ + 1), 32'd4);
        rd(sa(NREQ + 1), "R3 past array reads zero");
        wr(16'h2002, 32'd7);
        rd(sa(1), "R3 misaligned write ignored");
        rd(16'h2002, "R3 misaligned read zero");

        // R4 routing
        drive(16'h0001, "R4 id1 to ch2");
        drive(16'h0010, "R4 id5 to ch0");
        drive(16'h8000, "R4 last id to last ch");
        drive(16'h8011, "R4 combined pattern");
        drive(16'h0004, "R5 unmapped id3");
        drive(16'h0000, "R5 idle");

        // R6 out-of-range slot values
        wr(sa(3), 32'd9);
        wr(sa(4), 32'd15);
        drive(16'h000C, "R6 values above NUM_CH ignored");
        drive(16'h000D, "R6 with mapped id1");

        // R7 shared channel
        wr(sa(2), 32'd3);
        drive(16'h0002, "R7 id2 alone on ch2");
        drive(16'h0003, "R7 id1 and id2 ORed");
        drive(16'h0000, "R7 idle");

        // R5 unmap
        wr(sa(1), 32'd0);
        rd(sa(1), "R5 slot 1 cleared");
        drive(16'h0001, "R5 unmapped id1 ignored");

        // R9 truncated write data
        wr(sa(6), 32'h35);
        rd(sa(6), "R9 upper write bits dropped");
        drive(16'h0020, "R9 id6 to ch4");
        drive(16'h0000, "R9 idle");

        // R8 remap in the same cycle as a request
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = sa(7); bus_wdata = 32'd2;
        periph_req = 16'h0040;
        it.exp = model(16'h0040);
        it.tag = "R8 old mapping at write edge";
        sb_q.push_back(it);
        mslot[6] = 2;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        drive(16'h0040, "R8 new mapping next edge");
        drive(16'h0000, "R8 idle");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule